// File: doc/BRIEF.md
# Isochronous Endpoint Double Buffer

This block buffers the data of one isochronous USB endpoint. The `ep_is_in` configuration input picks the direction. The block holds two packet banks. At any time the local microcontroller bus owns one bank and the USB packet engine owns the other. The two banks swap owners on every start-of-frame strobe and at no other time. Packet completion and token traffic never move a bank, so data always crosses the block with exactly one frame of delay.

In the IN direction, the microcontroller writes the packet for the next frame into its bank. Each IN token then streams out, one byte per cycle, the bank that was filled during the previous frame. If that bank is empty, the block signals a zero-length packet. In the OUT direction, a received packet goes into the USB-side bank, and the microcontroller reads it after the next swap. Isochronous traffic carries no handshake, so the block never produces or waits for an acknowledgement. An active-low interrupt tells the microcontroller that a frame has begun.

Top module: `iso_pingpong_ep`

## Requirements
- R1: After reset, `irq_n` is 1, `loc_count` is 0, and `tx_valid` and `tx_zlp` are 0.
- R2: Bank ownership changes only on `sof`. An IN token sends the bytes written during the previous frame, and never the bytes written during the current frame.
- R3: `irq_n` goes to 0 in the cycle after `sof`. It stays 0 until `irq_clr` is seen without `sof`, and `sof` wins when both arrive together.
- R4: When `in_tok` arrives in the IN direction and the USB-side bank holds N>0 bytes, `tx_valid` is 1 for N cycles starting in the cycle after the token. The bytes come out in write order, and `tx_last` is 1 only on the N-th byte.
- R5: When `in_tok` arrives in the IN direction and the USB-side bank is empty, `tx_zlp` is 1 for exactly the next cycle and `tx_valid` stays 0.
- R6: Repeated IN tokens within one frame send identical data.
- R7: In the OUT direction, a packet whose `out_eop` arrives with `out_crc_ok`=1 becomes readable after the next `sof`. `loc_count` then equals its length, and each `loc_rd` pulse advances `loc_rdata` through its bytes in order, starting at byte 0.
- R8: An OUT packet that ends with `out_crc_ok`=0 is dropped, and `loc_count` reads 0 after the next swap.
- R9: A second OUT packet in the same frame replaces the first.
- R10: Each bank holds at most DEPTH (64) bytes. Local writes beyond DEPTH are ignored. On every swap the local byte pointer returns to 0, and in the IN direction the local bank count returns to 0.
- R11: The OUT byte stream has no effect in the IN direction, and `in_tok` has no effect in the OUT direction. No handshake output exists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ep_is_in | input | 1 | 1 = IN (device to host), 0 = OUT; static while running |
| sof | input | 1 | Start-of-frame strobe, swaps the banks |
| in_tok | input | 1 | IN token strobe |
| out_valid | input | 1 | Received OUT byte valid |
| out_data | input | 8 | Received OUT byte |
| out_eop | input | 1 | End of the received OUT packet |
| out_crc_ok | input | 1 | Packet CRC good, sampled with `out_eop` |
| loc_wr | input | 1 | Local byte write strobe (IN direction) |
| loc_wdata | input | 8 | Local write byte |
| loc_rd | input | 1 | Local byte read advance (OUT direction) |
| irq_clr | input | 1 | Interrupt clear strobe |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Final byte of the transmitted packet |
| tx_zlp | output | 1 | Send a zero-length packet |
| loc_rdata | output | 8 | Byte at the local read pointer |
| loc_count | output | 7 | Byte count of the local bank |
| irq_n | output | 1 | Active-low frame interrupt |

## Verification
The hardest case to reach is the one-frame delay. Data written or received in one frame must stay invisible until the next swap, and then appear exactly. The stimulus places IN tokens both before and after a swap, in frames whose local bank has just been filled. It also places good and bad OUT packets, and two packets in a single frame. A reference model inside the bench swaps its own two queues on each frame strobe to predict every transmitted byte. A full bank of 64 bytes plus six ignored extra writes probes the depth limit.

// File: rtl/iso_pp_pkg.sv
// Shared types for the isochronous double buffer.
// Assumes exactly two banks; the bank index is one bit wide.
package iso_pp_pkg;
    typedef enum logic {BANK_A = 1'b0, BANK_B = 1'b1} bank_t;

    // Return the bank that is not the given one.
    function automatic bank_t other_bank(input bank_t b);
        return bank_t'(~b);
    endfunction
endpackage

// File: rtl/iso_bank_store.sv
// Two packet banks. The local port writes and reads the bank chosen by sel.
// The USB port writes and reads the other bank.
// Assumes the two write ports never target the same bank (guaranteed by sel).
module iso_bank_store
    import iso_pp_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  bank_t         sel,
    input  logic          lw_en,
    input  logic [AW-1:0] l_addr,
    input  logic [DW-1:0] lw_data,
    input  logic          uw_en,
    input  logic [AW-1:0] uw_addr,
    input  logic [DW-1:0] uw_data,
    input  logic [AW-1:0] ur_addr,
    output logic [DW-1:0] lr_data,
    output logic [DW-1:0] ur_data
);
    logic [DW-1:0] lrd_b [2];
    logic [DW-1:0] urd_b [2];

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic [DW-1:0] store [DEPTH];
        logic          is_local;
        assign is_local = (sel == bank_t'(b));

        // Write the bank from whichever side owns it this frame.
        always_ff @(posedge clk) begin
            if (is_local && lw_en)
                store[l_addr] <= lw_data;
            else if (!is_local && uw_en)
                store[uw_addr] <= uw_data;
        end

        assign lrd_b[b] = store[l_addr];
        assign urd_b[b] = store[ur_addr];
    end

    assign lr_data = lrd_b[sel];
    assign ur_data = urd_b[other_bank(sel)];
endmodule

// File: rtl/iso_tx_stream.sv
// Streams the USB-side bank on each IN token, one byte per cycle.
// An empty bank yields a one-cycle zero-length indication instead.
// Assumes no new token and no frame strobe arrives while a packet is streaming.
module iso_tx_stream #(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ep_is_in,
    input  logic          in_tok,
    input  logic [CW-1:0] usb_len,
    output logic [AW-1:0] rd_addr,
    output logic          tx_valid,
    output logic          tx_last,
    output logic          tx_zlp
);
    logic          busy;
    logic [AW-1:0] ptr;
    logic [CW-1:0] len;

    assign rd_addr  = ptr;
    assign tx_valid = busy;
    assign tx_last  = busy && ((CW'(ptr) + CW'(1)) == len);

    // Start a burst or a zero-length packet on a token, then walk the bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            ptr    <= '0;
            len    <= '0;
            tx_zlp <= 1'b0;
        end else begin
            tx_zlp <= 1'b0;
            if (busy) begin
                if (tx_last) busy <= 1'b0;
                else         ptr  <= ptr + AW'(1);
            end else if (in_tok && ep_is_in) begin
                ptr <= '0;
                len <= usb_len;
                if (usb_len == '0) tx_zlp <= 1'b1;
                else               busy   <= 1'b1;
            end
        end
    end

    assert_last_ends_burst_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_last) |=> !tx_valid);
    assert_zlp_alone_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_zlp |-> !tx_valid);
    assert_zlp_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_zlp |=> !tx_zlp);
    assert_out_ignores_token_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_tok && !ep_is_in && !busy) |=> (!tx_zlp && !tx_valid));
endmodule

// File: rtl/iso_irq_ctl.sv
// Active-low frame interrupt: set by each frame strobe, cleared by the local side.
// Assumes the frame strobe takes priority over a clear in the same cycle.
module iso_irq_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic sof,
    input  logic irq_clr,
    output logic irq_n
);
    // Hold the request until cleared; a new frame re-raises it.
    always_ff @(posedge clk) begin
        if (!rst_n)       irq_n <= 1'b1;
        else if (sof)     irq_n <= 1'b0;
        else if (irq_clr) irq_n <= 1'b1;
    end

    assert_sof_raises_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sof |=> !irq_n);
    assert_irq_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n && !irq_clr) |=> !irq_n);
endmodule

// File: rtl/iso_pingpong_ep.sv
// Double-buffered isochronous endpoint. The two banks swap owners only on a
// frame strobe. The local side writes (IN) or reads (OUT) its bank byte by
// byte, and the USB side streams (IN) or captures (OUT) the other bank.
// Assumes ep_is_in is static while out of reset, and that no packet spans a frame strobe.
module iso_pingpong_ep
    import iso_pp_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ep_is_in,
    input  logic          sof,
    input  logic          in_tok,
    input  logic          out_valid,
    input  logic [DW-1:0] out_data,
    input  logic          out_eop,
    input  logic          out_crc_ok,
    input  logic          loc_wr,
    input  logic [DW-1:0] loc_wdata,
    input  logic          loc_rd,
    input  logic          irq_clr,
    output logic          tx_valid,
    output logic [DW-1:0] tx_data,
    output logic          tx_last,
    output logic          tx_zlp,
    output logic [DW-1:0] loc_rdata,
    output logic [CW-1:0] loc_count,
    output logic          irq_n
);
    bank_t         bank_sel;
    logic [CW-1:0] cnt [2];
    logic [CW-1:0] lptr;
    logic [CW-1:0] rxptr;
    logic          lw_en, uw_en, lrd_ok;
    logic [AW-1:0] tx_addr;
    logic [DW-1:0] ur_data;

    assign lw_en  = ep_is_in && loc_wr && !sof && (lptr < CW'(DEPTH));
    assign uw_en  = !ep_is_in && out_valid && !sof && (rxptr < CW'(DEPTH));
    assign lrd_ok = !ep_is_in && loc_rd && !sof && (lptr < cnt[bank_sel]);

    // Bank ownership, byte counts and the local and receive pointers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_sel <= BANK_A;
            cnt[0]   <= '0;
            cnt[1]   <= '0;
            lptr     <= '0;
            rxptr    <= '0;
        end else if (sof) begin
            bank_sel <= other_bank(bank_sel);
            lptr     <= '0;
            rxptr    <= '0;
            if (ep_is_in) cnt[other_bank(bank_sel)] <= '0;
            else          cnt[bank_sel]             <= '0;
        end else begin
            if (lw_en) begin
                cnt[bank_sel] <= lptr + CW'(1);
                lptr          <= lptr + CW'(1);
            end
            if (lrd_ok)
                lptr <= lptr + CW'(1);
            if (uw_en)
                rxptr <= rxptr + CW'(1);
            if (!ep_is_in && out_eop) begin
                cnt[other_bank(bank_sel)] <= out_crc_ok ? (uw_en ? rxptr + CW'(1) : rxptr) : '0;
                rxptr                     <= '0;
            end
        end
    end

    iso_bank_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk    (clk),
        .sel    (bank_sel),
        .lw_en  (lw_en),
        .l_addr (lptr[AW-1:0]),
        .lw_data(loc_wdata),
        .uw_en  (uw_en),
        .uw_addr(rxptr[AW-1:0]),
        .uw_data(out_data),
        .ur_addr(tx_addr),
        .lr_data(loc_rdata),
        .ur_data(ur_data)
    );

    iso_tx_stream #(.DEPTH(DEPTH)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .ep_is_in(ep_is_in),
        .in_tok  (in_tok),
        .usb_len (cnt[other_bank(bank_sel)]),
        .rd_addr (tx_addr),
        .tx_valid(tx_valid),
        .tx_last (tx_last),
        .tx_zlp  (tx_zlp)
    );

    assign tx_data   = tx_valid ? ur_data : '0;
    assign loc_count = cnt[bank_sel];

    iso_irq_ctl u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .sof    (sof),
        .irq_clr(irq_clr),
        .irq_n  (irq_n)
    );

    assert_bank_swaps_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sof |=> (bank_sel != $past(bank_sel)));
    assert_bank_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !sof |=> $stable(bank_sel));
    assert_count_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        loc_count <= CW'(DEPTH));
    assert_in_local_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sof && ep_is_in) |=> (loc_count == '0));
endmodule

// File: tb/sim_iso_pingpong_ep.sv
`timescale 1ns/1ps
module sim_iso_pingpong_ep;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ep_is_in = 1'b1;
    logic       sof = 0, in_tok = 0, out_valid = 0, out_eop = 0, out_crc_ok = 0;
    logic [7:0] out_data = 0, loc_wdata = 0;
    logic       loc_wr = 0, loc_rd = 0, irq_clr = 0;
    logic       tx_valid, tx_last, tx_zlp, irq_n;
    logic [7:0] tx_data, loc_rdata;
    logic [6:0] loc_count;

    int checks = 0;
    int errors = 0;

    // Scoreboard queue: {zlp, last, data}.
    logic [9:0] exp_q [$];
    // Reference model of the IN banks and of the OUT banks.
    logic [7:0] m_loc [$];
    logic [7:0] m_usb [$];
    logic [7:0] m_rx  [$];
    logic [7:0] m_rd  [$];

    always #2.5 clk = ~clk;

    iso_pingpong_ep u0 (
        .clk(clk), .rst_n(rst_n), .ep_is_in(ep_is_in), .sof(sof), .in_tok(in_tok),
        .out_valid(out_valid), .out_data(out_data), .out_eop(out_eop),
        .out_crc_ok(out_crc_ok), .loc_wr(loc_wr), .loc_wdata(loc_wdata),
        .loc_rd(loc_rd), .irq_clr(irq_clr), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_last(tx_last), .tx_zlp(tx_zlp), .loc_rdata(loc_rdata),
        .loc_count(loc_count), .irq_n(irq_n)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: pop one expected item for every transmit beat and compare.
    always @(negedge clk) begin
        if (rst_n && (tx_valid || tx_zlp)) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R11 unexpected transmit", {tx_zlp, tx_last, tx_data}, 0);
            end else begin
                logic [9:0] e;
                e = exp_q.pop_front();
                chk({tx_zlp, tx_last, tx_data} == e, e[9] ? "R5 zlp" : "R4/R2/R6 tx beat",
                    int'({tx_zlp, tx_last, tx_data}), int'(e));
            end
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        m_loc.delete(); m_usb.delete(); m_rx.delete(); m_rd.delete();
    endtask

    // Frame strobe; the model swaps its banks the same way.
    task automatic frame();
        sof = 1'b1; step(); sof = 1'b0;
        m_usb = m_loc; m_loc.delete();
        m_rd = m_rx; m_rx.delete();
    endtask

    task automatic wr_byte(input logic [7:0] d);
        loc_wr = 1'b1; loc_wdata = d; step(); loc_wr = 1'b0;
        if (m_loc.size() < 64) m_loc.push_back(d);
    endtask

    // Driver: push the expected beats, then issue the token.
    task automatic in_token();
        if (ep_is_in) begin
            if (m_usb.size() == 0) exp_q.push_back(10'h200);
            for (int i = 0; i < m_usb.size(); i++)
                exp_q.push_back({1'b0, (i == m_usb.size() - 1), m_usb[i]});
        end
        in_tok = 1'b1; step(); in_tok = 1'b0;
        repeat (m_usb.size() + 3) step();
    endtask

    task automatic out_pkt(input int n, input int seed, input logic good);
        m_rx.delete();
        for (int i = 0; i < n; i++) begin
            out_valid = 1'b1; out_data = 8'(seed + 7 * i); step();
            if (good) m_rx.push_back(8'(seed + 7 * i));
        end
        out_valid = 1'b0; out_eop = 1'b1; out_crc_ok = good; step();
        out_eop = 1'b0; out_crc_ok = 1'b0;
    endtask

    task automatic read_all(input string req);
        chk(loc_count == 7'(m_rd.size()), req, loc_count, m_rd.size());
        for (int i = 0; i < m_rd.size(); i++) begin
            chk(loc_rdata == m_rd[i], req, loc_rdata, m_rd[i]);
            loc_rd = 1'b1; step(); loc_rd = 1'b0;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // ---------------- IN direction ----------------
        ep_is_in = 1'b1;
        do_reset();
        @(negedge clk);
        chk(irq_n == 1'b1, "R1 irq_n", irq_n, 1);
        chk(loc_count == 0, "R1 loc_count", loc_count, 0);
        chk(!tx_valid && !tx_zlp, "R1 tx idle", tx_valid, 0);
        step();
        frame();
        chk(irq_n == 1'b0, "R3 irq after sof", irq_n, 0);
        step();
        chk(irq_n == 1'b0, "R3 irq held", irq_n, 0);
        irq_clr = 1'b1; step(); irq_clr = 1'b0;
        chk(irq_n == 1'b1, "R3 irq cleared", irq_n, 1);
        in_token();                       // R5: empty USB bank
        for (int i = 0; i < 5; i++) wr_byte(8'(8'hA0 + i));
        chk(loc_count == 5, "R10 local count", loc_count, 5);
        in_token();                       // R2: same-frame writes not visible
        irq_clr = 1'b1; sof = 1'b1; step(); irq_clr = 1'b0; sof = 1'b0;
        m_usb = m_loc; m_loc.delete();
        chk(irq_n == 1'b0, "R3 sof over clear", irq_n, 0);
        chk(loc_count == 0, "R10 local count after swap", loc_count, 0);
        in_token();                       // R2/R4: previous frame data
        in_token();                       // R6: repeated token
        for (int i = 0; i < 70; i++) wr_byte(8'(3 * i + 1));
        chk(loc_count == 64, "R10 saturate at depth", loc_count, 64);
        out_pkt(3, 8'h55, 1'b1);          // R11: OUT stream ignored in IN
        chk(loc_count == 64, "R11 out stream ignored", loc_count, 64);
        frame();
        in_token();                       // R4/R10: full 64-byte bank
        chk(exp_q.size() == 0, "R4 all beats seen", exp_q.size(), 0);

        // ---------------- OUT direction ----------------
        ep_is_in = 1'b0;
        do_reset();
        frame();
        out_pkt(4, 8'h10, 1'b1);
        in_token();                       // R11: token ignored in OUT
        chk(loc_count == 0, "R2 not visible before swap", loc_count, 0);
        frame();
        read_all("R7 good packet");
        out_pkt(5, 8'h20, 1'b0);
        frame();
        read_all("R8 bad crc dropped");
        out_pkt(6, 8'h30, 1'b1);
        out_pkt(3, 8'h40, 1'b1);
        frame();
        read_all("R9 second packet wins");
        out_pkt(2, 8'h60, 1'b1);
        loc_rd = 1'b1; step(); loc_rd = 1'b0;  // partial read, pointer must reset
        frame();
        read_all("R10 pointer reset on swap");
        chk(exp_q.size() == 0, "R4 queue drained", exp_q.size(), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule